// File: doc/BRIEF.md
# Host Bus Byte Adapter

This block connects a host processor bus to a 16-bit internal register file or shared memory. Every host cycle, marked by a rising edge on the host strobe, becomes one internal 16-bit read or write on a simple synchronous port. In wide mode a host cycle carries a full word. In byte mode the host moves one byte per cycle, and the adapter joins two bytes into one word for a write, or splits one word into two bytes for a read.

Three strap inputs set the meaning of the host lines. The polarity strap sets the sense of the read/write line in wide mode, and the sense of the byte-lane line in byte mode. The order strap sets which byte of a pair comes first; it matters only in byte mode. A space select sends each access to memory space or to register space. One acknowledge pulse closes each host cycle. A sticky flag records any byte that arrives out of the expected pair sequence.

Top module: `hbus_byte_adapter`

## Requirements
- R1: In wide mode (`cfgWide`=1) with `cfgPol`=1, `hostRw`=1 is a read and `hostRw`=0 is a write. With `cfgPol`=0 these two meanings swap.
- R2: A wide host cycle makes exactly one internal access (`intReq` high for one cycle). A write carries all 16 bits of `hostWrData` on `intWrData`. A read returns the 16-bit word on `hostRdData` while `hostAck` is high.
- R3: `hostSpace`=1 sends the access to memory space (`intMem`=1). `hostSpace`=0 sends it to register space (`intMem`=0).
- R4: In byte mode, data moves on bits [7:0]. With `cfgPol`=0, `hostLane`=0 selects the low byte (bits 7:0 of the word) and `hostLane`=1 selects the high byte. With `cfgPol`=1 the lane sense is inverted. Read bytes come back on `hostRdData[7:0]` with bits [15:8] at zero.
- R5: In byte mode, `cfgHiFirst`=1 expects each pair as high byte then low byte, and `cfgHiFirst`=0 expects low byte then high byte. The same order applies to reads and to writes. In wide mode `cfgHiFirst` and `hostLane` have no effect.
- R6: In byte mode, `hostRw`=1 always means a read and `hostRw`=0 always means a write, whatever the value of `cfgPol`.
- R7: In byte mode, the first write byte of a pair makes no internal access. The second write byte causes one internal write of the joined word, at the address and space given with the first byte.
- R8: In byte mode, the first read byte of a pair causes one internal read, and that word is latched. The second read byte comes from the latch with no internal access, so later changes to the stored word do not reach it.
- R9: A byte that does not match the expected lane, or whose direction differs from the held first byte, sets `seqErr`. `seqErr` stays set until reset. The pair then restarts with that byte as its first byte, and the pair completes on the opposite lane.
- R10: Each host cycle gives exactly one `hostAck` pulse, one cycle long. A strobe held high after its acknowledge does not start another cycle.
- R11: A change to `cfgWide`, `cfgPol` or `cfgHiFirst` while a byte pair is half done throws away the half pair. This does not set `seqErr`.
- R12: During and right after reset, `hostAck`, `intReq` and `seqErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWide | input | 1 | 1 = 16-bit host cycles, 0 = byte cycles |
| cfgPol | input | 1 | Polarity strap (read/write sense in wide mode, lane sense in byte mode) |
| cfgHiFirst | input | 1 | Byte pair order strap, 1 = high byte first |
| hostStb | input | 1 | Host cycle strobe; a rising edge starts a cycle |
| hostRw | input | 1 | Host read/write line |
| hostLane | input | 1 | Host byte-lane line |
| hostSpace | input | 1 | 1 = memory space, 0 = register space |
| hostAddr | input | ADDR_W | Host word address |
| hostWrData | input | WORD_W | Host write data |
| hostRdData | output | WORD_W | Host read data, valid while hostAck is high |
| hostAck | output | 1 | One-cycle acknowledge pulse |
| seqErr | output | 1 | Sticky byte sequence error flag |
| intReq | output | 1 | Internal access request, one cycle |
| intWe | output | 1 | Internal write enable |
| intMem | output | 1 | Internal space select, 1 = memory |
| intAddr | output | ADDR_W | Internal word address |
| intWrData | output | WORD_W | Internal write word |
| intRdData | input | WORD_W | Internal read word, valid one cycle after a read request |

## Verification
Wide cycles are run with both polarity settings and both space selects. The bench then checks that the read/write decode follows the strap, and that memory and register space stay separate. Byte pairs are run in both orders, with both lane senses, in both directions. These runs show whether the lane decode, the order strap and the fixed byte-mode read/write sense are each applied on their own. Out-of-order bytes, a strobe held high past its acknowledge, a word changed between the two halves of a read, and a strap toggle in the middle of a pair each produce a result that a wrong implementation could not match.

// File: rtl/hba_pkg.sv
package hba_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ACK   = 2'd3
  } hbaState_t;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic ldAddr;   // capture address and space
    logic ldWide;   // capture full host word
    logic ldByte;   // write host byte into lane laneHi
    logic ldRd;     // latch internal read word
    logic setLane;  // remember lane for byte read return
    logic laneHi;   // decoded lane of current byte
  } hbaStrobe_t;

endpackage

// File: rtl/hba_datapath.sv
module hba_datapath
  import hba_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbaStrobe_t        stb,
  input  logic              cfgWide,
  input  logic              hostSpace,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] intRdData,
  output logic [ADDR_W-1:0] intAddr,
  output logic              intMem,
  output logic [WORD_W-1:0] intWrData,
  output logic [WORD_W-1:0] hostRdData
);

  localparam int LANES  = 2;
  localparam int BYTE_W = WORD_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic              spaceQ;
  logic [WORD_W-1:0] rdWordQ;
  logic              rdHiQ;
  logic [BYTE_W-1:0] rdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      spaceQ <= 1'b0;
    end else if (stb.ldAddr) begin
      addrQ  <= hostAddr;
      spaceQ <= hostSpace;
    end
  end

  // Write word doubles as the byte holding register: each byte lands in its lane
  for (genvar b = 0; b < LANES; b++) begin : gLane
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (stb.ldWide) begin
        laneQ <= hostWrData[b*BYTE_W +: BYTE_W];
      end else if (stb.ldByte && (stb.laneHi == 1'(b))) begin
        laneQ <= hostWrData[BYTE_W-1:0];
      end
    end
    assign intWrData[b*BYTE_W +: BYTE_W] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWordQ <= '0;
      rdHiQ   <= 1'b0;
    end else begin
      if (stb.ldRd)    rdWordQ <= intRdData;
      if (stb.setLane) rdHiQ   <= stb.laneHi;
    end
  end

  always_comb begin
    rdByte = rdHiQ ? rdWordQ[WORD_W-1 -: BYTE_W] : rdWordQ[BYTE_W-1:0];
    if (cfgWide) hostRdData = rdWordQ;
    else         hostRdData = {{(WORD_W-BYTE_W){1'b0}}, rdByte};
  end

  assign intAddr = addrQ;
  assign intMem  = spaceQ;

  // Wide load and byte load never come together
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ldWide && stb.ldByte)) else $error("load conflict"); // R7

endmodule

// File: rtl/hba_ctrl.sv
module hba_ctrl
  import hba_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWide,
  input  logic       cfgPol,
  input  logic       cfgHiFirst,
  input  logic       hostStb,
  input  logic       hostRw,
  input  logic       hostLane,
  output hbaStrobe_t stb,
  output logic       intReq,
  output logic       intWe,
  output logic       hostAck,
  output logic       seqErr
);

  hbaState_t stateQ, stateD;
  logic       stbQ;
  logic       weQ, weD;
  logic       pairHalfQ, pairHalfD;
  logic       heldHiQ, heldHiD;
  logic       pairWeQ, pairWeD;
  logic       errQ, errD;
  logic [2:0] cfgQ;

  logic start, isRead, laneHi, expHi, secondOk, narrowErr, cfgChg;

  always_comb begin
    start     = hostStb && !stbQ && (stateQ == ST_IDLE);
    isRead    = cfgWide ? (cfgPol ? hostRw : !hostRw) : hostRw;
    laneHi    = cfgPol ? !hostLane : hostLane;
    expHi     = pairHalfQ ? !heldHiQ : cfgHiFirst;
    secondOk  = pairHalfQ && (laneHi == expHi) && (pairWeQ == !isRead);
    narrowErr = !secondOk && (pairHalfQ || (laneHi != cfgHiFirst));
    cfgChg    = ({cfgWide, cfgPol, cfgHiFirst} != cfgQ);
  end

  always_comb begin
    stb        = '0;
    stb.laneHi = laneHi;
    stateD     = stateQ;
    weD        = weQ;
    pairHalfD  = pairHalfQ;
    heldHiD    = heldHiQ;
    pairWeD    = pairWeQ;
    errD       = errQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          if (cfgWide) begin
            stb.ldAddr = 1'b1;
            stb.ldWide = 1'b1;
            weD        = !isRead;
            stateD     = ST_ISSUE;
          end else begin
            stb.setLane = 1'b1;
            if (narrowErr) errD = 1'b1;
            if (secondOk) begin
              pairHalfD = 1'b0;
              if (!isRead) begin
                stb.ldByte = 1'b1;
                weD        = 1'b1;
                stateD     = ST_ISSUE;
              end else begin
                stateD = ST_ACK;
              end
            end else begin
              pairHalfD  = 1'b1;
              heldHiD    = laneHi;
              pairWeD    = !isRead;
              stb.ldAddr = 1'b1;
              if (!isRead) begin
                stb.ldByte = 1'b1;
                stateD     = ST_ACK;
              end else begin
                weD    = 1'b0;
                stateD = ST_ISSUE;
              end
            end
          end
        end
      end
      ST_ISSUE: stateD = weQ ? ST_ACK : ST_WAIT;
      ST_WAIT: begin
        stb.ldRd = 1'b1;
        stateD   = ST_ACK;
      end
      ST_ACK:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
    if (cfgChg) pairHalfD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      stbQ      <= 1'b0;
      weQ       <= 1'b0;
      pairHalfQ <= 1'b0;
      heldHiQ   <= 1'b0;
      pairWeQ   <= 1'b0;
      errQ      <= 1'b0;
      cfgQ      <= '0;
    end else begin
      stateQ    <= stateD;
      stbQ      <= hostStb;
      weQ       <= weD;
      pairHalfQ <= pairHalfD;
      heldHiQ   <= heldHiD;
      pairWeQ   <= pairWeD;
      errQ      <= errD;
      cfgQ      <= {cfgWide, cfgPol, cfgHiFirst};
    end
  end

  assign intReq  = (stateQ == ST_ISSUE);
  assign intWe   = intReq && weQ;
  assign hostAck = (stateQ == ST_ACK);
  assign seqErr  = errQ;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck) else $error("ack longer than one cycle"); // R10
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    intReq |=> !intReq) else $error("request longer than one cycle"); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr) else $error("sequence flag cleared"); // R9
  AST_WIDE_NO_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWide && !cfgChg) |-> !pairHalfQ) else $error("half pair in wide mode"); // R11
  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> $past(stateQ) != ST_ACK) else $error("request right after ack"); // R10

endmodule

// File: rtl/hbus_byte_adapter.sv
module hbus_byte_adapter
  import hba_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWide,
  input  logic              cfgPol,
  input  logic              cfgHiFirst,
  input  logic              hostStb,
  input  logic              hostRw,
  input  logic              hostLane,
  input  logic              hostSpace,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              hostAck,
  output logic              seqErr,
  output logic              intReq,
  output logic              intWe,
  output logic              intMem,
  output logic [ADDR_W-1:0] intAddr,
  output logic [WORD_W-1:0] intWrData,
  input  logic [WORD_W-1:0] intRdData
);

  hbaStrobe_t stb;

  hba_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWide    (cfgWide),
    .cfgPol     (cfgPol),
    .cfgHiFirst (cfgHiFirst),
    .hostStb    (hostStb),
    .hostRw     (hostRw),
    .hostLane   (hostLane),
    .stb        (stb),
    .intReq     (intReq),
    .intWe      (intWe),
    .hostAck    (hostAck),
    .seqErr     (seqErr)
  );

  hba_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgWide    (cfgWide),
    .hostSpace  (hostSpace),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .intRdData  (intRdData),
    .intAddr    (intAddr),
    .intMem     (intMem),
    .intWrData  (intWrData),
    .hostRdData (hostRdData)
  );

endmodule

// File: tb/tb_hbus_byte_adapter.sv
module tb_hbus_byte_adapter;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cfgWide, cfgPol, cfgHiFirst;
  logic hostStb, hostRw, hostLane, hostSpace;
  logic [AW-1:0] hostAddr;
  logic [DW-1:0] hostWrData, hostRdData, intWrData, intRdData;
  logic hostAck, seqErr, intReq, intWe, intMem;
  logic [AW-1:0] intAddr;

  logic [DW-1:0] memArr [16];
  logic [DW-1:0] regArr [16];
  int reqCnt = 0;
  int errors = 0;
  int checks = 0;

  hbus_byte_adapter #(.ADDR_W(AW), .WORD_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgPol(cfgPol),
    .cfgHiFirst(cfgHiFirst), .hostStb(hostStb), .hostRw(hostRw),
    .hostLane(hostLane), .hostSpace(hostSpace), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostAck(hostAck),
    .seqErr(seqErr), .intReq(intReq), .intWe(intWe), .intMem(intMem),
    .intAddr(intAddr), .intWrData(intWrData), .intRdData(intRdData)
  );

  // Internal storage model with one-cycle read latency
  always @(posedge clk) begin
    if (rstN && intReq) begin
      reqCnt++;
      if (intWe) begin
        if (intMem) memArr[intAddr[3:0]] <= intWrData;
        else        regArr[intAddr[3:0]] <= intWrData;
      end else begin
        intRdData <= intMem ? memArr[intAddr[3:0]] : regArr[intAddr[3:0]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostOp(input logic rw, input logic lane, input logic space,
                        input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd);
    int n;
    n = 0;
    @(negedge clk);
    hostStb = 1'b1; hostRw = rw; hostLane = lane; hostSpace = space;
    hostAddr = addr; hostWrData = wd;
    do begin
      @(negedge clk);
      n++;
    end while (!hostAck && n < 50);
    chk("R10 ack seen", 32'(hostAck), 32'd1);
    rd = hostRdData;
    hostStb = 1'b0;
    @(negedge clk);
    chk("R10 ack one cycle", 32'(hostAck), 32'd0);
  endtask

  task automatic setCfg(input logic w, input logic p, input logic h);
    @(negedge clk);
    cfgWide = w; cfgPol = p; cfgHiFirst = h;
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R12 ack after reset", 32'(hostAck), 32'd0);
    chk("R12 req after reset", 32'(intReq), 32'd0);
    chk("R12 seqErr after reset", 32'(seqErr), 32'd0);
  endtask

  task automatic tWide();
    logic [DW-1:0] rd;
    int r0;
    setCfg(1'b1, 1'b1, 1'b0);
    r0 = reqCnt;
    hostOp(1'b0, 1'b0, 1'b1, 12'd3, 16'hA55A, rd);
    chk("R2 wide write stored", 32'(memArr[3]), 32'h0000A55A);
    chk("R2 one request", 32'(reqCnt - r0), 32'd1);
    hostOp(1'b1, 1'b0, 1'b1, 12'd3, 16'h0000, rd);
    chk("R1 pol1 high is read", 32'(rd), 32'h0000A55A);
    hostOp(1'b0, 1'b0, 1'b0, 12'd3, 16'hBEEF, rd);
    chk("R3 register space write", 32'(regArr[3]), 32'h0000BEEF);
    chk("R3 memory space untouched", 32'(memArr[3]), 32'h0000A55A);
    setCfg(1'b1, 1'b0, 1'b0);
    hostOp(1'b1, 1'b0, 1'b1, 12'd4, 16'h1234, rd);
    chk("R1 pol0 high is write", 32'(memArr[4]), 32'h00001234);
    hostOp(1'b0, 1'b0, 1'b0, 12'd3, 16'h0000, rd);
    chk("R1 pol0 low is read", 32'(rd), 32'h0000BEEF);
  endtask

  task automatic tWideOrder();
    logic [DW-1:0] rd;
    setCfg(1'b1, 1'b1, 1'b1);
    hostOp(1'b0, 1'b1, 1'b1, 12'd2, 16'hC3D4, rd);
    chk("R5 order strap ignored in wide write", 32'(memArr[2]), 32'h0000C3D4);
    hostOp(1'b1, 1'b0, 1'b1, 12'd2, 16'h0000, rd);
    chk("R5 order strap ignored in wide read", 32'(rd), 32'h0000C3D4);
  endtask

  task automatic tHold();
    int r0;
    setCfg(1'b1, 1'b1, 1'b0);
    r0 = reqCnt;
    @(negedge clk);
    hostStb = 1'b1; hostRw = 1'b1; hostSpace = 1'b1; hostAddr = 12'd3;
    repeat (8) @(negedge clk);
    hostStb = 1'b0;
    @(negedge clk);
    chk("R10 held strobe one access", 32'(reqCnt - r0), 32'd1);
  endtask

  task automatic tNarrowWrite();
    logic [DW-1:0] rd;
    int r0;
    setCfg(1'b0, 1'b0, 1'b0);
    r0 = reqCnt;
    hostOp(1'b0, 1'b0, 1'b1, 12'd5, 16'hFF34, rd);
    chk("R7 first byte no access", 32'(reqCnt - r0), 32'd0);
    chk("R7 first byte no store", 32'(memArr[5]), 32'h00000000);
    hostOp(1'b0, 1'b1, 1'b1, 12'd9, 16'hEE12, rd);
    chk("R7 joined word at first address", 32'(memArr[5]), 32'h00001234);
    chk("R7 single write", 32'(reqCnt - r0), 32'd1);
    setCfg(1'b0, 1'b1, 1'b0);
    hostOp(1'b0, 1'b1, 1'b1, 12'd6, 16'h00CD, rd);
    hostOp(1'b0, 1'b0, 1'b1, 12'd6, 16'h00AB, rd);
    chk("R4 inverted lane sense", 32'(memArr[6]), 32'h0000ABCD);
    setCfg(1'b0, 1'b0, 1'b1);
    hostOp(1'b0, 1'b1, 1'b1, 12'd7, 16'h0099, rd);
    hostOp(1'b0, 1'b0, 1'b1, 12'd7, 16'h0088, rd);
    chk("R5 high first write", 32'(memArr[7]), 32'h00009988);
    chk("R5 no error in order", 32'(seqErr), 32'd0);
  endtask

  task automatic tNarrowRead();
    logic [DW-1:0] rd;
    int r0;
    setCfg(1'b0, 1'b0, 1'b0);
    r0 = reqCnt;
    hostOp(1'b1, 1'b0, 1'b1, 12'd6, 16'h0000, rd);
    chk("R6 high rw reads with pol0", 32'(rd), 32'h000000CD);
    chk("R6 no write happened", 32'(memArr[6]), 32'h0000ABCD);
    chk("R8 first read byte one access", 32'(reqCnt - r0), 32'd1);
    memArr[6] = 16'h0000;
    hostOp(1'b1, 1'b1, 1'b1, 12'd6, 16'h0000, rd);
    chk("R8 second byte from latch", 32'(rd), 32'h000000AB);
    chk("R8 no second access", 32'(reqCnt - r0), 32'd1);
    setCfg(1'b0, 1'b0, 1'b1);
    hostOp(1'b1, 1'b1, 1'b1, 12'd7, 16'h0000, rd);
    chk("R5 high first read byte", 32'(rd), 32'h00000099);
    hostOp(1'b1, 1'b0, 1'b1, 12'd7, 16'h0000, rd);
    chk("R5 low second read byte", 32'(rd), 32'h00000088);
    chk("R5 read order no error", 32'(seqErr), 32'd0);
  endtask

  task automatic tDiscard();
    logic [DW-1:0] rd;
    int r0;
    setCfg(1'b0, 1'b0, 1'b0);
    r0 = reqCnt;
    hostOp(1'b0, 1'b0, 1'b1, 12'd10, 16'h0055, rd);
    setCfg(1'b0, 1'b1, 1'b0);
    setCfg(1'b0, 1'b0, 1'b0);
    hostOp(1'b0, 1'b0, 1'b1, 12'd11, 16'h0066, rd);
    hostOp(1'b0, 1'b1, 1'b1, 12'd11, 16'h0077, rd);
    chk("R11 new pair stored", 32'(memArr[11]), 32'h00007766);
    chk("R11 discarded pair not stored", 32'(memArr[10]), 32'h00000000);
    chk("R11 one write", 32'(reqCnt - r0), 32'd1);
    chk("R11 discard sets no error", 32'(seqErr), 32'd0);
  endtask

  task automatic tSeqErr();
    logic [DW-1:0] rd;
    setCfg(1'b0, 1'b0, 1'b0);
    hostOp(1'b0, 1'b1, 1'b1, 12'd8, 16'h0066, rd);
    chk("R9 wrong first lane flags", 32'(seqErr), 32'd1);
    hostOp(1'b0, 1'b0, 1'b1, 12'd8, 16'h0077, rd);
    chk("R9 restarted pair completes", 32'(memArr[8]), 32'h00006677);
    hostOp(1'b0, 1'b0, 1'b1, 12'd9, 16'h0011, rd);
    hostOp(1'b0, 1'b0, 1'b1, 12'd9, 16'h0022, rd);
    hostOp(1'b0, 1'b1, 1'b1, 12'd9, 16'h0033, rd);
    chk("R9 repeated lane restarts pair", 32'(memArr[9]), 32'h00003322);
    chk("R9 flag sticky", 32'(seqErr), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      memArr[i] = '0;
      regArr[i] = '0;
    end
    intRdData = '0;
    rstN = 1'b0; cfgWide = 1'b1; cfgPol = 1'b1; cfgHiFirst = 1'b0;
    hostStb = 1'b0; hostRw = 1'b0; hostLane = 1'b0; hostSpace = 1'b0;
    hostAddr = '0; hostWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 ack in reset", 32'(hostAck), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWide();
    tWideOrder();
    tHold();
    tNarrowWrite();
    tNarrowRead();
    tDiscard();
    tSeqErr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule